// File: doc/BRIEF.md
# Pending Function Event Queue

This block holds the function events that a PCI-style host bridge has raised and not yet handed over. Two kinds of record enter it. An error record carries a function identifier, a function handle, an error qualifier, a 64-bit fault address and a 16-bit event code. An availability record carries only an identifier, a handle and a code, and its qualifier and address fields are zero. A consumer takes the oldest record with a single-cycle pop request and gets back a registered response. The response has a status, a notification type, the record class and three big-endian 64-bit words. Each accepted insert raises a one-cycle notification pulse toward the channel subsystem. A level output shows whether any record is waiting.

The block also turns hot-plug and hot-unplug requests into the right series of availability records. It keeps a small per-slot table of identifier, handle and configured flag for this. Error posts from producers take priority over the sequencer. At most one record enters per cycle. When the queue is full, an insert is dropped and a sticky overflow flag is set.

Top module: `fn_event_queue`

## Requirements
- R1: After reset, pending_o, overflow_o, notify_o, rsp_valid_o and hp_busy_o are all 0.
- R2: An error post is stored with class 1 and is returned by a pop as w0 = {identifier, handle}, w1 = {qualifier, address[63:32]} and w2 = {address[31:0], code, 16'h0000}.
- R3: Availability records have class 2 and carry zero in the qualifier and address fields (w1 = 0, w2[63:32] = 0).
- R4: Records leave in exactly the order in which they were accepted.
- R5: The response registers update on the clock edge that samples pop_i, and rsp_valid_o is high for that one cycle. A pop of a non-empty queue returns status 0, notification type 2 and the head record. A pop of an empty queue returns status 1, type 0, class 0 and all-zero words.
- R6: notify_o is high for exactly the cycle after each accepted insert. pending_o is high whenever at least one record is stored.
- R7: A plug request stores the slot's identifier and handle and sets its configured flag. It then posts code 16'h0302 (reserved to standby) followed by 16'h0301 (standby to configured), in two consecutive cycles when no error post intervenes.
- R8: An unplug request posts 16'h0304 (configured to standby) only if the slot is configured, and always posts 16'h0308 (standby to reserved) afterwards. It clears the slot's configured flag, identifier and handle, so a later unplug of the same slot posts 16'h0308 with identifier and handle both zero.
- R9: A configure request sets or clears one slot's configured flag without posting a record.
- R10: An error post and a pending sequencer step in the same cycle store the error record first. The sequencer step is held until a cycle with no error post.
- R11: An insert arriving while DEPTH records are stored is dropped with no notify pulse, and overflow_o becomes 1 and stays 1 until reset.
- R12: While hp_busy_o is high, plug and unplug requests are ignored.
- R13: A pop and an insert in the same cycle on an empty queue report empty, and the new record stays queued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| err_post_i | input | 1 | Post an error record this cycle |
| err_fid_i | input | 32 | Error record function identifier |
| err_fh_i | input | 32 | Error record function handle |
| err_qual_i | input | 32 | Error qualifier |
| err_addr_i | input | 64 | Fault address |
| err_code_i | input | 16 | Error event code |
| plug_i | input | 1 | Hot-plug request |
| unplug_i | input | 1 | Hot-unplug request |
| hp_slot_i | input | SLOT_W (2) | Slot addressed by plug or unplug |
| hp_fid_i | input | 32 | Identifier of the plugged function |
| hp_fh_i | input | 32 | Handle of the plugged function |
| cfg_set_i | input | 1 | Configure request |
| cfg_slot_i | input | SLOT_W (2) | Slot addressed by configure request |
| cfg_val_i | input | 1 | New configured flag value |
| pop_i | input | 1 | Pop the oldest record |
| rsp_valid_o | output | 1 | Response valid, one cycle per pop |
| rsp_status_o | output | 1 | 0 = record returned, 1 = queue empty |
| rsp_nt_o | output | 8 | Notification type (2 on success) |
| rsp_cls_o | output | 2 | Record class (1 error, 2 availability) |
| rsp_w0_o | output | 64 | Response word 0, big-endian |
| rsp_w1_o | output | 64 | Response word 1, big-endian |
| rsp_w2_o | output | 64 | Response word 2, big-endian |
| pending_o | output | 1 | At least one record stored |
| notify_o | output | 1 | Pulse after each accepted insert |
| overflow_o | output | 1 | Sticky dropped-insert flag |
| hp_busy_o | output | 1 | Plug/unplug sequence in progress |

## Verification
A wrong read or write pointer shows up at the very next pop, either as a record out of order or as a stale record. A wrong count shows up as a mistimed pending_o edge, or as an overflow flag set too early or too late while the queue is being filled. A sequencer that picks the wrong branch or stores the wrong table entry first becomes visible when the affected records are popped, up to three records after the request. The missing or extra 16'h0304 record and the cleared handle on a repeated unplug are both checked at the response words.

// File: rtl/fneq_pkg.sv
package fneq_pkg;

    typedef enum logic [1:0] {
        CLS_NONE  = 2'd0,
        CLS_ERR   = 2'd1,
        CLS_AVAIL = 2'd2
    } evt_cls_e;

    typedef struct packed {
        evt_cls_e    cls;
        logic [31:0] fid;
        logic [31:0] fh;
        logic [31:0] qual;
        logic [63:0] addr;
        logic [15:0] code;
    } evt_rec_t;

    localparam logic [15:0] AV_STBY_TO_CFG = 16'h0301;
    localparam logic [15:0] AV_RSV_TO_STBY = 16'h0302;
    localparam logic [15:0] AV_CFG_TO_STBY = 16'h0304;
    localparam logic [15:0] AV_STBY_TO_RSV = 16'h0308;
    localparam logic [7:0]  NOTIFY_TYPE    = 8'd2;

endpackage

// File: rtl/fneq_store.sv
module fneq_store
    import fneq_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     push_i,
    input  evt_rec_t push_rec_i,
    input  logic     pop_i,
    output evt_rec_t head_o,
    output logic     empty_o,
    output logic     notify_o,
    output logic     pending_o,
    output logic     ovf_o
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

    typedef struct packed {
        logic [PTR_W-1:0] wr;
        logic [PTR_W-1:0] rd;
        logic [CNT_W-1:0] cnt;
        logic             ovf;
        logic             notify;
    } st_t;

    st_t      q, d;
    evt_rec_t mem [DEPTH];
    logic     full, push_ok, pop_ok;

    function automatic logic [PTR_W-1:0] ptr_step(input logic [PTR_W-1:0] p);
        return (p == PTR_LAST) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        d       = q;
        full    = (q.cnt == CNT_FULL);
        push_ok = push_i && !full;
        pop_ok  = pop_i && (q.cnt != '0);
        d.notify = push_ok;
        if (push_i && full) d.ovf = 1'b1;
        if (push_ok) d.wr = ptr_step(q.wr);
        if (pop_ok)  d.rd = ptr_step(q.rd);
        case ({push_ok, pop_ok})
            2'b10:   d.cnt = q.cnt + 1'b1;
            2'b01:   d.cnt = q.cnt - 1'b1;
            default: d.cnt = q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem[q.wr] <= push_rec_i;
    end

    assign head_o    = mem[q.rd];
    assign empty_o   = (q.cnt == '0);
    assign notify_o  = q.notify;
    assign pending_o = (q.cnt != '0);
    assign ovf_o     = q.ovf;

    // R11
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.cnt <= CNT_FULL);
    // R11
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.ovf |=> q.ovf);
    // R11
    drop_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && q.cnt == CNT_FULL && !pop_i) |=> (q.cnt == $past(q.cnt)) && !q.notify);
    // R6
    notify_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.notify |-> (q.cnt != '0));
endmodule

// File: rtl/fneq_hp_seq.sv
module fneq_hp_seq
    import fneq_pkg::*;
#(
    parameter int NSLOT = 4,
    localparam int SLOT_W = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              plug_i,
    input  logic              unplug_i,
    input  logic [SLOT_W-1:0] slot_i,
    input  logic [31:0]       fid_i,
    input  logic [31:0]       fh_i,
    input  logic              cfg_set_i,
    input  logic [SLOT_W-1:0] cfg_slot_i,
    input  logic              cfg_val_i,
    input  logic              grant_i,
    output logic              req_o,
    output evt_rec_t          rec_o,
    output logic              busy_o
);
    typedef enum logic [2:0] {
        SQ_IDLE = 3'd0,
        SQ_P1   = 3'd1,
        SQ_P2   = 3'd2,
        SQ_U1   = 3'd3,
        SQ_U2   = 3'd4
    } sq_e;

    typedef struct packed {
        sq_e                   st;
        logic [31:0]           fid;
        logic [31:0]           fh;
        logic [NSLOT-1:0][31:0] tab_fid;
        logic [NSLOT-1:0][31:0] tab_fh;
        logic [NSLOT-1:0]       tab_cfg;
    } st_t;

    st_t         q, d;
    logic [15:0] code;

    always_comb begin
        d     = q;
        req_o = 1'b0;
        code  = '0;
        case (q.st)
            SQ_P1: begin
                req_o = 1'b1;
                code  = AV_RSV_TO_STBY;
                if (grant_i) d.st = SQ_P2;
            end
            SQ_P2: begin
                req_o = 1'b1;
                code  = AV_STBY_TO_CFG;
                if (grant_i) d.st = SQ_IDLE;
            end
            SQ_U1: begin
                req_o = 1'b1;
                code  = AV_CFG_TO_STBY;
                if (grant_i) d.st = SQ_U2;
            end
            SQ_U2: begin
                req_o = 1'b1;
                code  = AV_STBY_TO_RSV;
                if (grant_i) d.st = SQ_IDLE;
            end
            default: ;
        endcase

        if (cfg_set_i) d.tab_cfg[cfg_slot_i] = cfg_val_i;

        if (q.st == SQ_IDLE) begin
            if (plug_i) begin
                d.tab_fid[slot_i] = fid_i;
                d.tab_fh[slot_i]  = fh_i;
                d.tab_cfg[slot_i] = 1'b1;
                d.fid = fid_i;
                d.fh  = fh_i;
                d.st  = SQ_P1;
            end else if (unplug_i) begin
                d.fid = q.tab_fid[slot_i];
                d.fh  = q.tab_fh[slot_i];
                d.st  = q.tab_cfg[slot_i] ? SQ_U1 : SQ_U2;
                d.tab_cfg[slot_i] = 1'b0;
                d.tab_fid[slot_i] = '0;
                d.tab_fh[slot_i]  = '0;
            end
        end

        rec_o = '{cls: CLS_AVAIL, fid: q.fid, fh: q.fh, qual: 32'h0, addr: 64'h0, code: code};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy_o = (q.st != SQ_IDLE);

    // R7
    plug_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == SQ_P1 && grant_i) |=> (q.st == SQ_P2));
    // R8
    unplug_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == SQ_U1 && grant_i) |=> (q.st == SQ_U2));
    // R10
    hold_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st != SQ_IDLE && !grant_i) |=> (q.st == $past(q.st)));
endmodule

// File: rtl/fneq_rsp.sv
module fneq_rsp
    import fneq_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        pop_i,
    input  logic        empty_i,
    input  evt_rec_t    head_i,
    output logic        valid_o,
    output logic        status_o,
    output logic [7:0]  nt_o,
    output logic [1:0]  cls_o,
    output logic [63:0] w0_o,
    output logic [63:0] w1_o,
    output logic [63:0] w2_o
);
    typedef struct packed {
        logic        valid;
        logic        status;
        logic [7:0]  nt;
        logic [1:0]  cls;
        logic [63:0] w0;
        logic [63:0] w1;
        logic [63:0] w2;
    } st_t;

    st_t q, d;

    always_comb begin
        d       = q;
        d.valid = pop_i;
        if (pop_i) begin
            if (empty_i) begin
                d.status = 1'b1;
                d.nt     = '0;
                d.cls    = CLS_NONE;
                d.w0     = '0;
                d.w1     = '0;
                d.w2     = '0;
            end else begin
                d.status = 1'b0;
                d.nt     = NOTIFY_TYPE;
                d.cls    = head_i.cls;
                d.w0     = {head_i.fid, head_i.fh};
                d.w1     = {head_i.qual, head_i.addr[63:32]};
                d.w2     = {head_i.addr[31:0], head_i.code, 16'h0000};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign valid_o  = q.valid;
    assign status_o = q.status;
    assign nt_o     = q.nt;
    assign cls_o    = q.cls;
    assign w0_o     = q.w0;
    assign w1_o     = q.w1;
    assign w2_o     = q.w2;

    // R5
    rsp_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop_i |=> valid_o);
    // R2
    cls_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && !empty_i) |-> (head_i.cls == CLS_ERR || head_i.cls == CLS_AVAIL));
    // R3
    avail_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && cls_o == CLS_AVAIL) |-> (w1_o == '0 && w2_o[63:32] == '0));
endmodule

// File: rtl/fn_event_queue.sv
module fn_event_queue
    import fneq_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int NSLOT = 4,
    localparam int SLOT_W = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              err_post_i,
    input  logic [31:0]       err_fid_i,
    input  logic [31:0]       err_fh_i,
    input  logic [31:0]       err_qual_i,
    input  logic [63:0]       err_addr_i,
    input  logic [15:0]       err_code_i,
    input  logic              plug_i,
    input  logic              unplug_i,
    input  logic [SLOT_W-1:0] hp_slot_i,
    input  logic [31:0]       hp_fid_i,
    input  logic [31:0]       hp_fh_i,
    input  logic              cfg_set_i,
    input  logic [SLOT_W-1:0] cfg_slot_i,
    input  logic              cfg_val_i,
    input  logic              pop_i,
    output logic              rsp_valid_o,
    output logic              rsp_status_o,
    output logic [7:0]        rsp_nt_o,
    output logic [1:0]        rsp_cls_o,
    output logic [63:0]       rsp_w0_o,
    output logic [63:0]       rsp_w1_o,
    output logic [63:0]       rsp_w2_o,
    output logic              pending_o,
    output logic              notify_o,
    output logic              overflow_o,
    output logic              hp_busy_o
);
    evt_rec_t seq_rec, err_rec, ins_rec, head;
    logic     seq_req, seq_grant, ins_valid, empty;

    always_comb begin
        err_rec   = '{cls: CLS_ERR, fid: err_fid_i, fh: err_fh_i, qual: err_qual_i,
                      addr: err_addr_i, code: err_code_i};
        seq_grant = seq_req && !err_post_i;
        ins_valid = err_post_i || seq_req;
        ins_rec   = err_post_i ? err_rec : seq_rec;
    end

    fneq_hp_seq #(.NSLOT(NSLOT)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .plug_i     (plug_i),
        .unplug_i   (unplug_i),
        .slot_i     (hp_slot_i),
        .fid_i      (hp_fid_i),
        .fh_i       (hp_fh_i),
        .cfg_set_i  (cfg_set_i),
        .cfg_slot_i (cfg_slot_i),
        .cfg_val_i  (cfg_val_i),
        .grant_i    (seq_grant),
        .req_o      (seq_req),
        .rec_o      (seq_rec),
        .busy_o     (hp_busy_o)
    );

    fneq_store #(.DEPTH(DEPTH)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_i     (ins_valid),
        .push_rec_i (ins_rec),
        .pop_i      (pop_i),
        .head_o     (head),
        .empty_o    (empty),
        .notify_o   (notify_o),
        .pending_o  (pending_o),
        .ovf_o      (overflow_o)
    );

    fneq_rsp u_rsp (
        .clk      (clk),
        .rst_n    (rst_n),
        .pop_i    (pop_i),
        .empty_i  (empty),
        .head_i   (head),
        .valid_o  (rsp_valid_o),
        .status_o (rsp_status_o),
        .nt_o     (rsp_nt_o),
        .cls_o    (rsp_cls_o),
        .w0_o     (rsp_w0_o),
        .w1_o     (rsp_w1_o),
        .w2_o     (rsp_w2_o)
    );

    // R10
    err_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_post_i && hp_busy_o) |=> hp_busy_o);
endmodule

// File: tb/fn_event_queue_tb.sv
module fn_event_queue_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        err_post_i = 0;
    logic [31:0] err_fid_i = 0, err_fh_i = 0, err_qual_i = 0;
    logic [63:0] err_addr_i = 0;
    logic [15:0] err_code_i = 0;
    logic        plug_i = 0, unplug_i = 0;
    logic [1:0]  hp_slot_i = 0;
    logic [31:0] hp_fid_i = 0, hp_fh_i = 0;
    logic        cfg_set_i = 0;
    logic [1:0]  cfg_slot_i = 0;
    logic        cfg_val_i = 0;
    logic        pop_i = 0;
    logic        rsp_valid_o, rsp_status_o;
    logic [7:0]  rsp_nt_o;
    logic [1:0]  rsp_cls_o;
    logic [63:0] rsp_w0_o, rsp_w1_o, rsp_w2_o;
    logic        pending_o, notify_o, overflow_o, hp_busy_o;

    int total = 0;
    int bad = 0;

    fn_event_queue #(.DEPTH(8), .NSLOT(4)) u_dut (.*);

    always #5 clk = ~clk;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic post_err(input logic [31:0] fid, input logic [31:0] fh,
                            input logic [31:0] qual, input logic [63:0] addr,
                            input logic [15:0] code);
        @(negedge clk);
        err_post_i = 1; err_fid_i = fid; err_fh_i = fh;
        err_qual_i = qual; err_addr_i = addr; err_code_i = code;
        @(negedge clk);
        err_post_i = 0;
    endtask

    task automatic do_pop();
        @(negedge clk);
        pop_i = 1;
        @(negedge clk);
        pop_i = 0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 20 && hp_busy_o; i++) @(negedge clk);
    endtask

    task automatic pop_avail(input string req, input logic [15:0] code,
                             input logic [63:0] w0);
        do_pop();
        chk({req, " status"}, rsp_status_o, 0);
        chk({req, " class"}, rsp_cls_o, 2);
        chk({req, " w0"}, rsp_w0_o, w0);
        chk({req, " code"}, rsp_w2_o[31:16], code);
        chk("R3 avail qualifier/addr zero", {rsp_w1_o | rsp_w2_o[63:32]}, 0);
    endtask

    task automatic pop_empty(input string req);
        do_pop();
        chk({req, " empty status"}, rsp_status_o, 1);
    endtask

    task automatic t_reset();
        chk("R1 pending", pending_o, 0);
        chk("R1 overflow", overflow_o, 0);
        chk("R1 notify", notify_o, 0);
        chk("R1 rsp_valid", rsp_valid_o, 0);
        chk("R1 busy", hp_busy_o, 0);
    endtask

    task automatic t_empty_pop();
        do_pop();
        chk("R5 valid", rsp_valid_o, 1);
        chk("R5 empty status", rsp_status_o, 1);
        chk("R5 empty nt", rsp_nt_o, 0);
        chk("R5 empty class", rsp_cls_o, 0);
        chk("R5 empty words", rsp_w0_o | rsp_w1_o | rsp_w2_o, 0);
        @(negedge clk);
        chk("R5 valid one cycle", rsp_valid_o, 0);
    endtask

    task automatic t_err_single();
        post_err(32'hCAFE0001, 32'h80000005, 32'h12345678, 64'h0011223344556677, 16'h00A5);
        chk("R6 notify after insert", notify_o, 1);
        chk("R6 pending", pending_o, 1);
        do_pop();
        chk("R6 notify single cycle", notify_o, 0);
        chk("R5 status ok", rsp_status_o, 0);
        chk("R5 nt", rsp_nt_o, 2);
        chk("R2 class", rsp_cls_o, 1);
        chk("R2 w0", rsp_w0_o, 64'hCAFE0001_80000005);
        chk("R2 w1", rsp_w1_o, 64'h12345678_00112233);
        chk("R2 w2", rsp_w2_o, 64'h44556677_00A5_0000);
        chk("R6 pending cleared", pending_o, 0);
    endtask

    task automatic t_order();
        post_err(32'hA1, 0, 0, 0, 1);
        post_err(32'hA2, 0, 0, 0, 2);
        post_err(32'hA3, 0, 0, 0, 3);
        for (int i = 1; i <= 3; i++) begin
            do_pop();
            chk("R4 order fid", rsp_w0_o[63:32], 32'hA0 + i);
        end
        pop_empty("R4");
    endtask

    task automatic t_plug();
        @(negedge clk);
        plug_i = 1; hp_slot_i = 1; hp_fid_i = 32'h11; hp_fh_i = 32'h80000011;
        @(negedge clk);
        plug_i = 0;
        chk("R7 busy", hp_busy_o, 1);
        @(negedge clk);
        chk("R7 first notify", notify_o, 1);
        @(negedge clk);
        chk("R7 second notify", notify_o, 1);
        chk("R7 idle after two", hp_busy_o, 0);
        pop_avail("R7 first", 16'h0302, 64'h00000011_80000011);
        pop_avail("R7 second", 16'h0301, 64'h00000011_80000011);
        pop_empty("R7");
    endtask

    task automatic unplug(input logic [1:0] slot);
        @(negedge clk);
        unplug_i = 1; hp_slot_i = slot;
        @(negedge clk);
        unplug_i = 0;
        wait_idle();
    endtask

    task automatic t_unplug_cfg();
        unplug(1);
        pop_avail("R8 cfg-to-stby", 16'h0304, 64'h00000011_80000011);
        pop_avail("R8 stby-to-rsv", 16'h0308, 64'h00000011_80000011);
        pop_empty("R8");
        unplug(1);
        pop_avail("R8 repeat cleared handle", 16'h0308, 64'h0);
        pop_empty("R8 repeat single");
    endtask

    task automatic t_cfg();
        @(negedge clk);
        plug_i = 1; hp_slot_i = 2; hp_fid_i = 32'h22; hp_fh_i = 32'h80000022;
        @(negedge clk);
        plug_i = 0;
        wait_idle();
        do_pop(); do_pop();
        @(negedge clk);
        cfg_set_i = 1; cfg_slot_i = 2; cfg_val_i = 0;
        @(negedge clk);
        cfg_set_i = 0;
        chk("R9 configure posts nothing", notify_o, 0);
        chk("R9 queue still empty", pending_o, 0);
        unplug(2);
        pop_avail("R9 deconfigured unplug", 16'h0308, 64'h00000022_80000022);
        pop_empty("R9");
        @(negedge clk);
        cfg_set_i = 1; cfg_slot_i = 3; cfg_val_i = 1;
        @(negedge clk);
        cfg_set_i = 0;
        unplug(3);
        pop_avail("R9 configured by request", 16'h0304, 64'h0);
        pop_avail("R9 then reserved", 16'h0308, 64'h0);
        pop_empty("R9 end");
    endtask

    task automatic t_prio();
        @(negedge clk);
        plug_i = 1; hp_slot_i = 0; hp_fid_i = 32'h33; hp_fh_i = 32'h80000033;
        @(negedge clk);
        plug_i = 0;
        err_post_i = 1; err_fid_i = 32'hEE; err_fh_i = 0; err_qual_i = 0;
        err_addr_i = 0; err_code_i = 16'h0009;
        @(negedge clk);
        err_post_i = 0;
        chk("R10 sequencer held", hp_busy_o, 1);
        wait_idle();
        do_pop();
        chk("R10 error first class", rsp_cls_o, 1);
        chk("R10 error first fid", rsp_w0_o[63:32], 32'hEE);
        pop_avail("R10 plug step a", 16'h0302, 64'h00000033_80000033);
        pop_avail("R10 plug step b", 16'h0301, 64'h00000033_80000033);
        pop_empty("R10");
    endtask

    task automatic t_busy();
        @(negedge clk);
        plug_i = 1; hp_slot_i = 1; hp_fid_i = 32'h44; hp_fh_i = 32'h80000044;
        @(negedge clk);
        plug_i = 0;
        unplug_i = 1; hp_slot_i = 1;
        @(negedge clk);
        unplug_i = 0;
        wait_idle();
        pop_avail("R12 plug a", 16'h0302, 64'h00000044_80000044);
        pop_avail("R12 plug b", 16'h0301, 64'h00000044_80000044);
        pop_empty("R12 unplug ignored");
    endtask

    task automatic t_same_cycle();
        @(negedge clk);
        pop_i = 1;
        err_post_i = 1; err_fid_i = 32'h55; err_fh_i = 0; err_qual_i = 0;
        err_addr_i = 0; err_code_i = 1;
        @(negedge clk);
        pop_i = 0; err_post_i = 0;
        chk("R13 pop reports empty", rsp_status_o, 1);
        chk("R13 record kept", pending_o, 1);
        do_pop();
        chk("R13 record fid", rsp_w0_o[63:32], 32'h55);
        pop_empty("R13");
    endtask

    task automatic t_overflow();
        for (int i = 0; i < 8; i++) post_err(32'hB0 + i, 0, 0, 0, 16'(i));
        chk("R11 no overflow when exactly full", overflow_o, 0);
        post_err(32'hBF, 0, 0, 0, 16'hF);
        chk("R11 dropped no notify", notify_o, 0);
        chk("R11 overflow set", overflow_o, 1);
        for (int i = 0; i < 8; i++) begin
            do_pop();
            chk("R11 kept records fid", rsp_w0_o[63:32], 32'hB0 + i);
        end
        pop_empty("R11 dropped record absent");
        chk("R11 overflow sticky", overflow_o, 1);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog act=running exp=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_empty_pop();
        t_err_single();
        t_order();
        t_plug();
        t_unplug_cfg();
        t_cfg();
        t_prio();
        t_busy();
        t_same_cycle();
        t_overflow();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule